// File: doc/BRIEF.md
# Configuration Header Ratio Detector

This block sits beside the path that carries a configuration image into a programmable device and watches, without altering, the 32-bit words of the image header as they go by. Two flag fields sit at fixed positions deep in that header: a two-bit encryption mode field and a single compression indicator. The block captures both. From them and from the selected configuration bus width it works out the clock-to-data ratio code that the programming interface needs for the image that follows.

A caller first pulses the start input, with the width select set for the image. It then streams the words with a valid qualifier and marks the final word of the image with a last flag. Once the compression word has been accepted, the block presents the ratio code and both flags. In the same cycle a one-cycle result strobe fires. If the image ends before the compression word arrives, the block raises an error flag and gives no result. That error stays raised until the next start.

Top module: `hdr_ratio_detect`

## Requirements
- R1: After reset, ratio_o, encrypted_o, compressed_o, result_valid_o and short_err_o are all 0. Words offered before the first start pulse are not counted and produce no result.
- R2: encrypted_o is 1 when bits [3:2] of the word at index 69 (the 70th accepted word after start) are nonzero, and 0 otherwise.
- R3: compressed_o is 1 when bit 1 of the word at index 229 (the 230th accepted word) is 0, and 0 when that bit is 1.
- R4: With width32_i = 0 (16-bit), the ratio code is 1 (x2) for an encrypted image that is not compressed, and 2 (x4) for any compressed image. The code encoding is 0=x1, 1=x2, 2=x4, 3=x8.
- R5: With width32_i = 1 (32-bit), the ratio code is 2 (x4) for encrypted-only and 3 (x8) for any compressed image. An image that is neither encrypted nor compressed gets code 0 (x1) at either width.
- R6: result_valid_o is high for exactly one cycle, in the cycle after the word at index 229 is accepted. ratio_o, encrypted_o and compressed_o are valid in that same cycle and hold their values until the next start.
- R7: A start pulse restarts the word count and clears every output to 0. A word presented in the same cycle as start is dropped.
- R8: If last_i accompanies an accepted word whose index is below 229, short_err_o rises in the next cycle and no result is given. Further words are ignored until the next start. last_i on word 229 itself gives a normal result with no error.
- R9: The width is sampled on the start pulse. Changes to width32_i later in the stream do not affect the result.
- R10: Cycles with word_valid_i low do not advance the word count.
- R11: After a result, further words are ignored: there is no second strobe and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin inspecting a new image; samples width32_i |
| width32_i | input | 1 | Configuration width: 1 = 32-bit, 0 = 16-bit |
| word_valid_i | input | 1 | word_i carries an image word this cycle |
| word_i | input | 32 | Image word |
| last_i | input | 1 | The current valid word is the final word of the image |
| ratio_o | output | 2 | Clock-to-data ratio code (0=x1, 1=x2, 2=x4, 3=x8) |
| encrypted_o | output | 1 | Captured encryption indicator |
| compressed_o | output | 1 | Captured compression indicator |
| result_valid_o | output | 1 | One-cycle strobe marking a fresh result |
| short_err_o | output | 1 | Image ended before the compression word |

## Verification
The hardest situations to reach from the ports are the ones where the word count would be off by one: a word arriving in the very cycle of the start pulse, a restart partway through an image, and gaps in the valid stream. The stimulus fills every header word except the two flag words with a pattern that reads as both encrypted and compressed. Any miscount therefore captures the wrong word and shows up as a wrong ratio code or an early strobe. Images that end early, both before and after the encryption word, cover the error path. The error cases then keep streaming words to show that no late result appears.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;

  typedef enum logic [1:0] {
    RATIO_X1 = 2'd0,
    RATIO_X2 = 2'd1,
    RATIO_X4 = 2'd2,
    RATIO_X8 = 2'd3
  } ratio_e;

endpackage

// File: rtl/hdr_word_tracker.sv
module hdr_word_tracker #(
  parameter int ENC_IDX = 69,
  parameter int CMP_IDX = 229,
  localparam int IDX_W  = $clog2(CMP_IDX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic word_valid_i,
  input  logic last_i,
  output logic hit_enc_o,
  output logic hit_cmp_o,
  output logic early_end_o
);

  logic [IDX_W-1:0] count_q;
  logic             armed_q;
  logic             accept;

  assign accept      = word_valid_i && armed_q && !start_i;
  assign hit_enc_o   = accept && (count_q == IDX_W'(ENC_IDX));
  assign hit_cmp_o   = accept && (count_q == IDX_W'(CMP_IDX));
  assign early_end_o = accept && last_i && (count_q != IDX_W'(CMP_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      armed_q <= 1'b0;
    end else if (start_i) begin
      count_q <= '0;
      armed_q <= 1'b1;
    end else if (accept) begin
      count_q <= count_q + 1'b1;
      if (hit_cmp_o || last_i) armed_q <= 1'b0;
    end
  end

  // R10: the count never runs past the compression index while armed
  p_count_bound_r10: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (count_q <= IDX_W'(CMP_IDX)));

  // R8: an accepted final word disarms the tracker
  p_last_disarms_r8: assert property (@(posedge clk) disable iff (rst)
    (accept && last_i) |=> !armed_q);

endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
  parameter int DATA_W  = 32,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              width32_i,
  input  logic              hit_enc_i,
  input  logic [DATA_W-1:0] word_i,
  output logic              enc_seen_o,
  output logic              wide_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      enc_seen_o <= 1'b0;
      wide_o     <= 1'b0;
    end else if (start_i) begin
      enc_seen_o <= 1'b0;
      wide_o     <= width32_i;
    end else if (hit_enc_i) begin
      enc_seen_o <= |word_i[ENC_LSB +: ENC_W];
    end
  end

  // R9: the latched width only moves on a start pulse
  p_width_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(wide_o));

endmodule

// File: rtl/hdr_ratio_encode.sv
module hdr_ratio_encode
  import hdr_ratio_pkg::*;
(
  input  logic   enc_i,
  input  logic   cmp_i,
  input  logic   wide_i,
  output ratio_e code_o
);

  logic [1:0] base;

  always_comb begin
    base = cmp_i ? 2'(RATIO_X4) : 2'(RATIO_X2);
    if (!enc_i && !cmp_i) code_o = RATIO_X1;
    else                  code_o = ratio_e'(base + {1'b0, wide_i});
  end

endmodule

// File: rtl/hdr_ratio_detect.sv
module hdr_ratio_detect
  import hdr_ratio_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ENC_IDX = 69,
  parameter int ENC_LSB = 2,
  parameter int ENC_W   = 2,
  parameter int CMP_IDX = 229,
  parameter int CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              width32_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              last_i,
  output logic [1:0]        ratio_o,
  output logic              encrypted_o,
  output logic              compressed_o,
  output logic              result_valid_o,
  output logic              short_err_o
);

  logic   hit_enc, hit_cmp, early_end;
  logic   enc_seen, wide;
  logic   cmp_now;
  ratio_e code;

  hdr_word_tracker #(
    .ENC_IDX (ENC_IDX),
    .CMP_IDX (CMP_IDX)
  ) u_track (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .word_valid_i (word_valid_i),
    .last_i       (last_i),
    .hit_enc_o    (hit_enc),
    .hit_cmp_o    (hit_cmp),
    .early_end_o  (early_end)
  );

  hdr_flag_capture #(
    .DATA_W  (DATA_W),
    .ENC_LSB (ENC_LSB),
    .ENC_W   (ENC_W)
  ) u_cap (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .width32_i  (width32_i),
    .hit_enc_i  (hit_enc),
    .word_i     (word_i),
    .enc_seen_o (enc_seen),
    .wide_o     (wide)
  );

  // compression indicator is active low in the header word
  assign cmp_now = !word_i[CMP_BIT];

  hdr_ratio_encode u_enc (
    .enc_i  (enc_seen),
    .cmp_i  (cmp_now),
    .wide_i (wide),
    .code_o (code)
  );

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      ratio_o        <= '0;
      encrypted_o    <= 1'b0;
      compressed_o   <= 1'b0;
      result_valid_o <= 1'b0;
      short_err_o    <= 1'b0;
    end else begin
      result_valid_o <= hit_cmp;
      if (hit_cmp) begin
        ratio_o      <= code;
        encrypted_o  <= enc_seen;
        compressed_o <= cmp_now;
      end
      if (early_end) short_err_o <= 1'b1;
    end
  end

  // R6: the result strobe lasts a single cycle
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    result_valid_o |=> !result_valid_o);

  // R8: an error and a result never appear together
  p_err_no_result_r8: assert property (@(posedge clk) disable iff (rst)
    short_err_o |-> !result_valid_o);

  // R8: the error stays until a start
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (short_err_o && !start_i) |=> short_err_o);

  // R7: a start leaves no strobe and no error behind
  p_start_clears_r7: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!result_valid_o && !short_err_o && ratio_o == 2'd0));

  // R5: a plain image always yields the x1 code
  p_plain_x1_r5: assert property (@(posedge clk) disable iff (rst)
    (result_valid_o && !encrypted_o && !compressed_o) |-> (ratio_o == 2'd0));

  // R4: any flagged image never yields the x1 code
  p_flagged_not_x1_r4: assert property (@(posedge clk) disable iff (rst)
    (result_valid_o && (encrypted_o || compressed_o)) |-> (ratio_o != 2'd0));

endmodule

// File: tb/tb_hdr_ratio_detect.sv
module tb_hdr_ratio_detect;

  logic        clk = 1'b0;
  logic        rst;
  logic        start_i;
  logic        width32_i;
  logic        word_valid_i;
  logic [31:0] word_i;
  logic        last_i;
  logic [1:0]  ratio_o;
  logic        encrypted_o;
  logic        compressed_o;
  logic        result_valid_o;
  logic        short_err_o;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #5 clk = ~clk;

  hdr_ratio_detect dut (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .width32_i      (width32_i),
    .word_valid_i   (word_valid_i),
    .word_i         (word_i),
    .last_i         (last_i),
    .ratio_o        (ratio_o),
    .encrypted_o    (encrypted_o),
    .compressed_o   (compressed_o),
    .result_valid_o (result_valid_o),
    .short_err_o    (short_err_o)
  );

  always @(posedge clk) if (result_valid_o) pulses++;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    summary();
    $finish;
  end

  // expected ratio from the requirement table (R4, R5)
  function automatic logic [1:0] exp_ratio(input logic w32, input logic enc, input logic cmp);
    case ({w32, enc, cmp})
      3'b000:  return 2'd0;
      3'b001:  return 2'd2;
      3'b010:  return 2'd1;
      3'b011:  return 2'd2;
      3'b100:  return 2'd0;
      3'b101:  return 2'd3;
      3'b110:  return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // filler reads as encrypted and compressed; only the two flag words differ
  function automatic logic [31:0] img_word(input int idx, input logic [1:0] encf, input logic cbit);
    logic [31:0] w;
    w = 32'hA5A5_A5A5;
    if (idx == 69)  w[3:2] = encf;
    if (idx == 229) w[1]   = cbit;
    return w;
  endfunction

  task automatic do_start(input logic w32);
    @(negedge clk);
    start_i   = 1'b1;
    width32_i = w32;
    @(negedge clk);
    start_i   = 1'b0;
  endtask

  task automatic send_words(input int first, input int n, input logic [1:0] encf,
                            input logic cbit, input bit gaps, input bit mark_last);
    for (int i = first; i < first + n; i++) begin
      @(negedge clk);
      word_valid_i = 1'b1;
      word_i       = img_word(i, encf, cbit);
      last_i       = mark_last && (i == first + n - 1);
      if (gaps && (i % 7 == 3) && (i != first + n - 1)) begin
        @(negedge clk);
        word_valid_i = 1'b0;
        last_i       = 1'b0;
      end
    end
    @(negedge clk);
    word_valid_i = 1'b0;
    last_i       = 1'b0;
  endtask

  task automatic run_case(input logic w32, input logic [1:0] encf, input logic cbit,
                          input string req);
    logic [1:0] er;
    er = exp_ratio(w32, encf != 2'b00, !cbit);
    do_start(w32);
    send_words(0, 230, encf, cbit, 0, 1);
    chk(req, "strobe", result_valid_o, 1);
    chk(req, "ratio", ratio_o, er);
    chk("R2", "encrypted", encrypted_o, encf != 2'b00);
    chk("R3", "compressed", compressed_o, !cbit);
    chk("R8", "no error on full image", short_err_o, 0);
    @(negedge clk);
    chk("R6", "strobe one cycle", result_valid_o, 0);
    chk("R6", "ratio held", ratio_o, er);
  endtask

  task automatic t_reset();
    int p0;
    chk("R1", "ratio", ratio_o, 0);
    chk("R1", "encrypted", encrypted_o, 0);
    chk("R1", "compressed", compressed_o, 0);
    chk("R1", "strobe", result_valid_o, 0);
    chk("R1", "error", short_err_o, 0);
    p0 = pulses;
    send_words(0, 230, 2'b00, 1'b0, 0, 1);
    repeat (2) @(negedge clk);
    chk("R1", "no result before start", pulses, p0);
    chk("R1", "ratio idle", ratio_o, 0);
  endtask

  task automatic t_table();
    for (int w = 0; w < 2; w++) begin
      run_case(w[0], 2'b00, 1'b1, "R5");
      run_case(w[0], 2'b01, 1'b1, w[0] ? "R5" : "R4");
      run_case(w[0], 2'b10, 1'b0, w[0] ? "R5" : "R4");
      run_case(w[0], 2'b00, 1'b0, w[0] ? "R5" : "R4");
      run_case(w[0], 2'b11, 1'b1, w[0] ? "R5" : "R4");
    end
  endtask

  task automatic t_after_result();
    int p0;
    run_case(1'b1, 2'b01, 1'b1, "R5");
    p0 = pulses;
    send_words(0, 240, 2'b00, 1'b0, 0, 0);
    repeat (2) @(negedge clk);
    chk("R11", "no second strobe", pulses, p0);
    chk("R11", "ratio unchanged", ratio_o, 2);
    chk("R11", "compressed unchanged", compressed_o, 0);
  endtask

  task automatic t_short(input int n);
    int p0;
    do_start(1'b0);
    p0 = pulses;
    send_words(0, n, 2'b00, 1'b1, 0, 1);
    chk("R8", "error raised", short_err_o, 1);
    chk("R8", "no strobe", result_valid_o, 0);
    send_words(n, 240 - n, 2'b00, 1'b1, 0, 0);
    repeat (2) @(negedge clk);
    chk("R8", "no late result", pulses, p0);
    chk("R8", "error sticky", short_err_o, 1);
    do_start(1'b0);
    chk("R7", "start clears error", short_err_o, 0);
    chk("R7", "start clears ratio", ratio_o, 0);
  endtask

  task automatic t_start_clears_result();
    run_case(1'b1, 2'b00, 1'b0, "R5");
    do_start(1'b0);
    chk("R7", "ratio cleared", ratio_o, 0);
    chk("R7", "compressed cleared", compressed_o, 0);
  endtask

  task automatic t_gaps();
    do_start(1'b1);
    send_words(0, 230, 2'b01, 1'b1, 1, 1);
    chk("R10", "strobe with gaps", result_valid_o, 1);
    chk("R10", "ratio with gaps", ratio_o, 2);
    chk("R10", "encrypted with gaps", encrypted_o, 1);
  endtask

  task automatic t_width_late();
    do_start(1'b0);
    @(negedge clk);
    width32_i = 1'b1;
    send_words(0, 230, 2'b00, 1'b0, 0, 1);
    chk("R9", "late width ignored", ratio_o, 2);
    width32_i = 1'b0;
  endtask

  task automatic t_start_with_word();
    @(negedge clk);
    start_i      = 1'b1;
    width32_i    = 1'b0;
    word_valid_i = 1'b1;
    word_i       = 32'hA5A5_A5A5;
    @(negedge clk);
    start_i      = 1'b0;
    word_valid_i = 1'b0;
    send_words(0, 230, 2'b00, 1'b1, 0, 1);
    chk("R7", "word at start dropped: strobe", result_valid_o, 1);
    chk("R7", "word at start dropped: ratio", ratio_o, 0);
    chk("R7", "word at start dropped: enc", encrypted_o, 0);
  endtask

  task automatic t_restart();
    do_start(1'b1);
    send_words(0, 100, 2'b11, 1'b0, 0, 0);
    run_case(1'b1, 2'b00, 1'b1, "R7");
  endtask

  initial begin
    rst          = 1'b1;
    start_i      = 1'b0;
    width32_i    = 1'b0;
    word_valid_i = 1'b0;
    word_i       = '0;
    last_i       = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_table();
    t_after_result();
    t_short(150);
    t_short(50);
    t_start_clears_result();
    t_gaps();
    t_width_late();
    t_start_with_word();
    t_restart();
    summary();
    $finish;
  end

endmodule